// File: doc/BRIEF.md
# Interrupt Acceptance and Processor Status Register

This block keeps the processor status word of a 16-bit core and decides, once per instruction, whether a pending interrupt request preempts the running program. The status word has three fields. A privilege flag sits in bit 15. A three-bit running priority sits in bits 10:8. The negative/zero/positive result flags sit in bits 2:0. Every other bit reads as zero. The core pulses `boundary` in the cycle between the store phase of one instruction and the fetch of the next. Only in that cycle is a request compared against the running priority.

When a request wins, `takeIrq` rises in the same cycle. On the following edge the block captures the status word and the program counter that the core must push, and it switches the status word to supervisor at the request's priority. It also forms the address of the vector-table entry from which the core fetches the service routine's start. A separate restore strobe reloads the whole status word from a supplied value, which models the return from a service routine. The result flags follow every register write the core reports.

Top module: `intr_accept_unit`

## Requirements
- R1: While `rstN` is low and after it is released, `statusOut` is 16'h0002 (supervisor, priority 0, Z set), and `savedStatus`, `savedPc` and `vecAddr` are zero.
- R2: Bits 14:11 and 7:3 of `statusOut` and of `savedStatus` are always zero.
- R3: When `ccWr` is high and `restoreEn` is low, the next `statusOut[2:0]` is 3'b100 if `ccResult[15]` is 1, 3'b010 if `ccResult` is zero, and 3'b001 otherwise. The other fields are unaffected unless an interrupt is taken in the same cycle.
- R4: `takeIrq` is high in a cycle exactly when `boundary`, `irqReq` and `irqLevel > statusOut[10:8]` all hold and `restoreEn` is low. It is combinational in that cycle.
- R5: A request whose level is equal to or below `statusOut[10:8]`, or that arrives without `boundary`, is not taken and does not change privilege or priority.
- R6: One cycle after `takeIrq`, `savedStatus` holds the `statusOut` value seen in the take cycle and `savedPc` holds that cycle's `pcIn`. Both registers hold their values until the next take.
- R7: One cycle after `takeIrq`, `statusOut[15]` is 0, `statusOut[10:8]` equals the accepted `irqLevel`, and the flags are kept. If `ccWr` was high in the take cycle, the flags follow R3 instead.
- R8: One cycle after `takeIrq`, `vecAddr` equals 16'h0100 plus the zero-extended `irqVector`, and it holds that value until the next take.
- R9: When `restoreEn` is high, the next `statusOut` is `restoreValue & 16'h8707`. A restore overrides a flag update and suppresses any interrupt in that cycle.
- R10: While the running priority is 7, no request is taken at any level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | High in the cycle between store and next fetch |
| irqReq | input | 1 | Interrupt request pending |
| irqLevel | input | 3 | Priority of the pending request |
| irqVector | input | 8 | Vector number of the pending request |
| pcIn | input | 16 | Address of the next instruction |
| ccWr | input | 1 | A register write completed this cycle |
| ccResult | input | 16 | Value written, used to derive the flags |
| restoreEn | input | 1 | Reload the status word |
| restoreValue | input | 16 | Status word to reload |
| takeIrq | output | 1 | Request accepted this cycle |
| savedStatus | output | 16 | Status word captured at acceptance |
| savedPc | output | 16 | Program counter captured at acceptance |
| statusOut | output | 16 | Current status word |
| vecAddr | output | 16 | Vector-table entry address of the accepted request |

## Verification
The hardest cases to reach from the ports are a request exactly at the running level and a request while the running level is 7. Both need the priority raised first, and that takes either an earlier acceptance or a restore. The random stimulus issues restores often, with random values that include junk in the reserved bits, so the running level moves across its whole range. Directed steps pin the equal-level, level-7, restore-during-boundary and flag-update-during-take cases.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int WORD_W = 16;
  localparam int LVL_W  = 3;
  localparam int CC_W   = 3;
  localparam int VEC_W  = 8;
  localparam int PRIV_BIT = 15;
  localparam int LVL_LO   = 8;
  localparam int LVL_HI   = LVL_LO + LVL_W - 1;
  localparam logic [WORD_W-1:0] STATUS_MASK  = 16'h8707;
  localparam logic [WORD_W-1:0] RESET_STATUS = 16'h0002;

  typedef struct packed {
    logic takeEn;
    logic ccEn;
    logic restoreEn;
  } strobe_t;
endpackage

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intr_pkg::*;
(
  input  logic             boundary,
  input  logic             irqReq,
  input  logic [LVL_W-1:0] irqLevel,
  input  logic [LVL_W-1:0] curLevel,
  input  logic             ccWr,
  input  logic             restoreEn,
  output strobe_t          strobe
);
  logic outranks;
  assign outranks = irqLevel > curLevel;

  always_comb begin
    strobe.restoreEn = restoreEn;
    strobe.takeEn    = boundary && irqReq && outranks && !restoreEn;
    strobe.ccEn      = ccWr && !restoreEn;
  end
endmodule

// File: rtl/intr_datapath.sv
module intr_datapath
  import intr_pkg::*;
#(
  parameter logic [WORD_W-1:0] VEC_BASE = 16'h0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [LVL_W-1:0]  irqLevel,
  input  logic [VEC_W-1:0]  irqVector,
  input  logic [WORD_W-1:0] pcIn,
  input  logic [WORD_W-1:0] ccResult,
  input  logic [WORD_W-1:0] restoreValue,
  output logic [LVL_W-1:0]  curLevel,
  output logic [WORD_W-1:0] statusOut,
  output logic [WORD_W-1:0] savedStatus,
  output logic [WORD_W-1:0] savedPc,
  output logic [WORD_W-1:0] vecAddr
);
  localparam int PAD_W = WORD_W - VEC_W;

  logic             privReg;
  logic [LVL_W-1:0] lvlReg;
  logic [CC_W-1:0]  ccReg;
  logic [CC_W-1:0]  ccNext;
  logic [WORD_W-1:0] restoreMasked;

  always_comb begin
    ccNext[2] = ccResult[WORD_W-1];
    ccNext[1] = (ccResult == '0);
    ccNext[0] = !ccResult[WORD_W-1] && (ccResult != '0);
  end

  assign restoreMasked = restoreValue & STATUS_MASK;

  always_comb begin
    statusOut = '0;
    statusOut[PRIV_BIT]      = privReg;
    statusOut[LVL_HI:LVL_LO] = lvlReg;
    statusOut[CC_W-1:0]      = ccReg;
  end

  assign curLevel = lvlReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      privReg <= RESET_STATUS[PRIV_BIT];
      lvlReg  <= RESET_STATUS[LVL_HI:LVL_LO];
      ccReg   <= RESET_STATUS[CC_W-1:0];
    end else if (strobe.restoreEn) begin
      privReg <= restoreMasked[PRIV_BIT];
      lvlReg  <= restoreMasked[LVL_HI:LVL_LO];
      ccReg   <= restoreMasked[CC_W-1:0];
    end else begin
      if (strobe.takeEn) begin
        privReg <= 1'b0;
        lvlReg  <= irqLevel;
      end
      if (strobe.ccEn) ccReg <= ccNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedStatus <= '0;
      savedPc     <= '0;
      vecAddr     <= '0;
    end else if (strobe.takeEn) begin
      savedStatus <= statusOut;
      savedPc     <= pcIn;
      vecAddr     <= VEC_BASE + {{PAD_W{1'b0}}, irqVector};
    end
  end
endmodule

// File: rtl/intr_accept_unit.sv
module intr_accept_unit
  import intr_pkg::*;
#(
  parameter logic [15:0] VEC_BASE = 16'h0100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        boundary,
  input  logic        irqReq,
  input  logic [2:0]  irqLevel,
  input  logic [7:0]  irqVector,
  input  logic [15:0] pcIn,
  input  logic        ccWr,
  input  logic [15:0] ccResult,
  input  logic        restoreEn,
  input  logic [15:0] restoreValue,
  output logic        takeIrq,
  output logic [15:0] savedStatus,
  output logic [15:0] savedPc,
  output logic [15:0] statusOut,
  output logic [15:0] vecAddr
);
  strobe_t          strobe;
  logic [LVL_W-1:0] curLevel;

  intr_ctrl u_ctrl (
    .boundary (boundary),
    .irqReq   (irqReq),
    .irqLevel (irqLevel),
    .curLevel (curLevel),
    .ccWr     (ccWr),
    .restoreEn(restoreEn),
    .strobe   (strobe)
  );

  intr_datapath #(.VEC_BASE(VEC_BASE)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .irqLevel    (irqLevel),
    .irqVector   (irqVector),
    .pcIn        (pcIn),
    .ccResult    (ccResult),
    .restoreValue(restoreValue),
    .curLevel    (curLevel),
    .statusOut   (statusOut),
    .savedStatus (savedStatus),
    .savedPc     (savedPc),
    .vecAddr     (vecAddr)
  );

  assign takeIrq = strobe.takeEn;
endmodule

// File: rtl/intr_accept_chk.sv
module intr_accept_chk (
  input logic        clk,
  input logic        rstN,
  input logic        boundary,
  input logic        irqReq,
  input logic [2:0]  irqLevel,
  input logic [7:0]  irqVector,
  input logic [15:0] pcIn,
  input logic        ccWr,
  input logic [15:0] ccResult,
  input logic        restoreEn,
  input logic [15:0] restoreValue,
  input logic        takeIrq,
  input logic [15:0] savedStatus,
  input logic [15:0] savedPc,
  input logic [15:0] statusOut,
  input logic [15:0] vecAddr
);
  assert_flags_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ccWr && !restoreEn) |=> $countones(statusOut[2:0]) == 1);

  assert_no_take_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel <= statusOut[10:8]) |-> !takeIrq);

  assert_no_take_offboundary_R4: assert property (@(posedge clk) disable iff (!rstN)
    !boundary |-> !takeIrq);

  assert_saved_state_R6: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |=> (savedPc == $past(pcIn)) && (savedStatus == $past(statusOut)));

  assert_new_level_R7: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |=> (statusOut[10:8] == $past(irqLevel)) && !statusOut[15]);

  assert_vector_addr_R8: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |=> vecAddr == (16'h0100 + {8'h00, $past(irqVector)}));

  assert_restore_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    restoreEn |=> statusOut == ($past(restoreValue) & 16'h8707));

  assert_top_level_R10: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[10:8] == 3'd7) |-> !takeIrq);
endmodule

bind intr_accept_unit intr_accept_chk u_chk (.*);

// File: tb/intr_accept_unit_bench.sv
`timescale 1ns/1ps
module intr_accept_unit_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        boundary, irqReq, ccWr, restoreEn;
  logic [2:0]  irqLevel;
  logic [7:0]  irqVector;
  logic [15:0] pcIn, ccResult, restoreValue;
  logic        takeIrq;
  logic [15:0] savedStatus, savedPc, statusOut, vecAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] mStatus, mSavedSt, mSavedPc, mVec;
  string lastTag;

  always #4 clk = ~clk;

  intr_accept_unit u_intr_accept_unit (.*);

  function automatic logic [2:0] flagsOf(input logic [15:0] v);
    if (v[15]) return 3'b100;
    if (v == 16'h0000) return 3'b010;
    return 3'b001;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkRegs();
    check(lastTag, "statusOut", statusOut, mStatus);
    check("R2", "reserved bits", statusOut & 16'h78F8, 16'h0000);
    check("R6", "savedStatus", savedStatus, mSavedSt);
    check("R6", "savedPc", savedPc, mSavedPc);
    check("R8", "vecAddr", vecAddr, mVec);
  endtask

  task automatic step(input logic b, input logic rq, input logic [2:0] lv,
                      input logic [7:0] vc, input logic [15:0] pc,
                      input logic cw, input logic [15:0] res,
                      input logic rs, input logic [15:0] rv);
    logic expTake;
    logic [15:0] nxt;
    boundary = b; irqReq = rq; irqLevel = lv; irqVector = vc; pcIn = pc;
    ccWr = cw; ccResult = res; restoreEn = rs; restoreValue = rv;
    #1;
    expTake = b && rq && !rs && (lv > mStatus[10:8]);
    if (mStatus[10:8] == 3'd7) check("R10", "takeIrq", {15'd0, takeIrq}, 16'd0);
    else if (rs && b && rq) check("R9", "takeIrq under restore", {15'd0, takeIrq}, {15'd0, expTake});
    else if (expTake) check("R4", "takeIrq", {15'd0, takeIrq}, 16'd1);
    else check("R5", "takeIrq", {15'd0, takeIrq}, 16'd0);
    nxt = mStatus;
    if (rs) begin
      nxt = rv & 16'h8707; lastTag = "R9";
    end else begin
      lastTag = "R5";
      if (cw) begin nxt[2:0] = flagsOf(res); lastTag = "R3"; end
      if (expTake) begin
        nxt[15] = 1'b0; nxt[10:8] = lv; lastTag = "R7";
        mSavedSt = mStatus; mSavedPc = pc; mVec = 16'h0100 + {8'h00, vc};
      end
    end
    mStatus = nxt;
    @(posedge clk);
    @(negedge clk);
    checkRegs();
  endtask

  initial begin
    rstN = 1'b0; boundary = 0; irqReq = 0; irqLevel = 0; irqVector = 0;
    pcIn = 0; ccWr = 0; ccResult = 0; restoreEn = 0; restoreValue = 0;
    void'($urandom(32'd20240917));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "statusOut in reset", statusOut, 16'h0002);
    rstN = 1'b1;
    mStatus = 16'h0002; mSavedSt = 0; mSavedPc = 0; mVec = 0; lastTag = "R1";
    @(posedge clk); @(negedge clk);
    checkRegs();
    check("R1", "takeIrq after reset", {15'd0, takeIrq}, 16'd0);

    // flags for negative, zero, positive results
    step(0, 0, 0, 0, 16'h3000, 1, 16'h8001, 0, 0);
    step(0, 0, 0, 0, 16'h3001, 1, 16'h0000, 0, 0);
    step(0, 0, 0, 0, 16'h3002, 1, 16'h0005, 0, 0);
    // request without boundary
    step(0, 1, 3'd5, 8'h80, 16'h3003, 0, 0, 0, 0);
    // restore with junk reserved bits: running at level 3
    step(0, 0, 0, 0, 16'h3004, 0, 0, 1, 16'hFBFC | 16'h0301);
    // equal level refused, higher accepted with flag update
    step(1, 1, 3'd3, 8'h21, 16'h3005, 0, 0, 0, 0);
    step(1, 1, 3'd4, 8'hFF, 16'h3006, 1, 16'hFFFF, 0, 0);
    step(1, 1, 3'd2, 8'h10, 16'h3007, 0, 0, 0, 0);
    // restore during boundary suppresses the take
    step(1, 1, 3'd6, 8'h33, 16'h3008, 0, 0, 1, 16'h8002);
    // top level: nothing accepted
    step(0, 0, 0, 0, 16'h3009, 0, 0, 1, 16'h8701);
    step(1, 1, 3'd7, 8'h44, 16'h300A, 0, 0, 0, 0);
    step(0, 0, 0, 0, 16'h300B, 0, 0, 1, 16'h8002);
    step(1, 1, 3'd7, 8'h00, 16'h300C, 0, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 2) == 0, ($urandom % 2) == 0, 3'($urandom),
           8'($urandom), 16'($urandom), ($urandom % 3) == 0, 16'($urandom),
           ($urandom % 8) == 0, 16'($urandom));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule